// File: doc/BRIEF.md
# Self-Checking One-Hot Sequencer with Illegal-State Recovery

This block is a sixteen-position sequencer held in a one-hot state register. Position 0 is the idle position. While the register holds a legal code, an advance input walks the single hot bit one place up, wrapping from the top position back to idle. While advance is low the position holds.

A two-tier legality checker watches the register at all times. The first tier splits the vector into four 4-bit groups and sorts each group into one of three classes: no bit set, exactly one bit set, or more than one bit set. The second tier calls the vector legal only when exactly one group is in the "exactly one" class and no group is in the "more than one" class. A checker that only reported "exactly one" per group would accept vectors such as 16'hFEC1, which has many bits set. Whenever the vector is illegal, the next clock edge loads the idle code, so an upset register recovers in one cycle.

A fault-injection mask lets a test corrupt the register on purpose. The reset request is asserted asynchronously and released through a synchronizer, so every state flip-flop leaves reset on the same edge. All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `onehot_guard_fsm`

## Requirements
- R1: The state register is 16 bits wide and one-hot. While reset is active it holds the idle code 16'h0001 (bit 0 set, all other bits clear).
- R2: Driving rst_n_i low forces state_o to 16'h0001 and illegal_seen_o to 0 at once, without waiting for a clock edge.
- R3: Reset is released synchronously. After rst_n_i rises, with advance_i held high, state_o stays at 16'h0001 through the first and second rising edges and becomes 16'h0002 at the third.
- R4: illegal_o is combinational and is 1 exactly when the number of set bits in state_o differs from 1. The all-zero vector counts as illegal.
- R5: The check is built from bit groups [4g+3:4g], g = 0..3, each sorted as zero, one or many set bits. The vector is legal only when exactly one group has one bit set and no group has many. For example, 16'hFEC1 is illegal.
- R6: If illegal_o is 1 at a rising edge, the next state is the idle code 16'h0001 XOR inj_mask_i, whatever advance_i is.
- R7: If the state is legal and advance_i is 1 at a rising edge, the hot bit moves from position i to position (i+1) mod 16.
- R8: If the state is legal and advance_i is 0 at a rising edge, the state holds.
- R9: At each rising edge the next state computed under R6 to R8 is XORed with inj_mask_i before it is loaded. A zero mask changes nothing.
- R10: illegal_seen_o equals the value illegal_o had in the previous clock cycle. It is a single registered copy, not sticky, and it is 0 during reset.
- R11: idx_o is the position of the lowest set bit of state_o, and 0 when no bit is set. For a legal state this is the hot position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Active-low reset request; asserts asynchronously, released synchronously inside the block |
| advance_i | input | 1 | Step the hot bit one position up when the state is legal |
| inj_mask_i | input | 16 | Fault-injection mask XORed into the next state at each edge |
| state_o | output | 16 | Current state register |
| illegal_o | output | 1 | Combinational flag: state_o is not a legal one-hot code |
| illegal_seen_o | output | 1 | illegal_o delayed by one clock cycle |
| idx_o | output | 4 | Position of the lowest set bit of state_o |

## Verification
illegal_o and idx_o are combinational, so they are due in the same cycle as the state they describe. state_o changes one rising edge after advance_i or inj_mask_i is applied. illegal_seen_o lags illegal_o by exactly one edge. Reset assertion acts at once, and on release the first step appears at the third rising edge. The bench drives inputs at the falling edge and samples every output at the next falling edge, after exactly one rising edge. It tracks the expected state arithmetically from R6 to R9. Its exhaustive sweep steers the register through all 65536 vectors with the injection mask, one vector per cycle.

// File: rtl/ogf_pkg.sv
package ogf_pkg;

  // Class a bit group can fall into, as reported by the first tier
  typedef enum logic [1:0] {
    GRP_ZERO = 2'd0,
    GRP_ONE  = 2'd1,
    GRP_MANY = 2'd2
  } grp_class_e;

endpackage

// File: rtl/ogf_rst_sync.sv
// Reset synchronizer: asserts asynchronously, releases after STAGES edges.
module ogf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_o
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      shift_q <= '0;
    end else begin
      shift_q <= {shift_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_o = ~shift_q[STAGES-1];

endmodule

// File: rtl/ogf_group_class.sv
// First tier: classify one bit group as zero, one or many bits set.
module ogf_group_class
  import ogf_pkg::*;
#(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] grp_i,
  output grp_class_e         class_o
);

  localparam int CNT_W = $clog2(GROUP_W + 1);

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int b = 0; b < GROUP_W; b++) begin
      ones = ones + CNT_W'(grp_i[b]);
    end
  end

  always_comb begin
    if (ones == '0) begin
      class_o = GRP_ZERO;
    end else if (ones == CNT_W'(1)) begin
      class_o = GRP_ONE;
    end else begin
      class_o = GRP_MANY;
    end
  end

endmodule

// File: rtl/ogf_legality.sv
// Two-tier legality check of a one-hot vector.
module ogf_legality
  import ogf_pkg::*;
#(
  parameter  int GROUP_W  = 4,
  parameter  int N_GROUPS = 4,
  localparam int STATE_W  = GROUP_W * N_GROUPS
) (
  input  logic [STATE_W-1:0] state_i,
  output logic               illegal_o
);

  localparam int GCNT_W = $clog2(N_GROUPS + 1);

  grp_class_e        cls [N_GROUPS];
  logic [GCNT_W-1:0] n_single;
  logic              any_many;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_tier1
    ogf_group_class #(
      .GROUP_W(GROUP_W)
    ) u_class (
      .grp_i  (state_i[g*GROUP_W +: GROUP_W]),
      .class_o(cls[g])
    );
  end

  // Second tier: one single-bit group and no crowded group
  always_comb begin
    n_single = '0;
    any_many = 1'b0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (cls[g] == GRP_ONE) begin
        n_single = n_single + GCNT_W'(1);
      end
      if (cls[g] == GRP_MANY) begin
        any_many = 1'b1;
      end
    end
  end

  assign illegal_o = any_many || (n_single != GCNT_W'(1));

endmodule

// File: rtl/ogf_index.sv
// Position of the lowest set bit; zero when no bit is set.
module ogf_index #(
  parameter  int STATE_W = 16,
  localparam int IDX_W   = $clog2(STATE_W)
) (
  input  logic [STATE_W-1:0] vec_i,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    idx_o = '0;
    for (int b = STATE_W - 1; b >= 0; b--) begin
      if (vec_i[b]) begin
        idx_o = IDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/onehot_guard_fsm.sv
// One-hot sequencer with two-tier legality check and one-cycle recovery.
module onehot_guard_fsm #(
  parameter  int GROUP_W     = 4,
  parameter  int N_GROUPS    = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int STATE_W     = GROUP_W * N_GROUPS,
  localparam int IDX_W       = $clog2(STATE_W)
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               advance_i,
  input  logic [STATE_W-1:0] inj_mask_i,
  output logic [STATE_W-1:0] state_o,
  output logic               illegal_o,
  output logic               illegal_seen_o,
  output logic [IDX_W-1:0]   idx_o
);

  localparam logic [STATE_W-1:0] IDLE = STATE_W'(1);

  logic               rst_act;
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] base_nxt;
  logic               bad;
  logic               bad_q;

  ogf_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_n_i(rst_n_i),
    .rst_o  (rst_act)
  );

  ogf_legality #(
    .GROUP_W (GROUP_W),
    .N_GROUPS(N_GROUPS)
  ) u_legality (
    .state_i  (state_q),
    .illegal_o(bad)
  );

  ogf_index #(
    .STATE_W(STATE_W)
  ) u_index (
    .vec_i(state_q),
    .idx_o(idx_o)
  );

  // Recovery has priority over the application step
  always_comb begin
    if (bad) begin
      base_nxt = IDLE;
    end else if (advance_i) begin
      base_nxt = {state_q[STATE_W-2:0], state_q[STATE_W-1]};
    end else begin
      base_nxt = state_q;
    end
  end

  always_ff @(posedge clk_i or posedge rst_act) begin
    if (rst_act) begin
      state_q <= IDLE;
      bad_q   <= 1'b0;
    end else begin
      state_q <= base_nxt ^ inj_mask_i;
      bad_q   <= bad;
    end
  end

  assign state_o        = state_q;
  assign illegal_o      = bad;
  assign illegal_seen_o = bad_q;

endmodule

// File: rtl/onehot_guard_fsm_chk.sv
// Property checker, bound to the top module.
module onehot_guard_fsm_chk #(
  parameter int STATE_W = 16,
  parameter int IDX_W   = 4
) (
  input logic               clk_i,
  input logic               rst_act,
  input logic               advance_i,
  input logic [STATE_W-1:0] inj_mask_i,
  input logic [STATE_W-1:0] state_o,
  input logic               illegal_o,
  input logic               illegal_seen_o,
  input logic [IDX_W-1:0]   idx_o
);

  localparam logic [STATE_W-1:0] IDLE = STATE_W'(1);

  a_r4_flag_matches_popcount: assert property (
    @(posedge clk_i) disable iff (rst_act)
    illegal_o == ($countones(state_o) != 1)
  ) else $error("a_r4_flag_matches_popcount");

  a_r6_recover_to_idle: assert property (
    @(posedge clk_i) disable iff (rst_act)
    illegal_o |=> state_o == (IDLE ^ $past(inj_mask_i))
  ) else $error("a_r6_recover_to_idle");

  a_r7_rotate_on_advance: assert property (
    @(posedge clk_i) disable iff (rst_act)
    (!illegal_o && advance_i) |=>
      state_o == ({$past(state_o[STATE_W-2:0]), $past(state_o[STATE_W-1])} ^ $past(inj_mask_i))
  ) else $error("a_r7_rotate_on_advance");

  a_r8_hold_when_idle_step: assert property (
    @(posedge clk_i) disable iff (rst_act)
    (!illegal_o && !advance_i) |=> state_o == ($past(state_o) ^ $past(inj_mask_i))
  ) else $error("a_r8_hold_when_idle_step");

  a_r10_seen_is_delayed: assert property (
    @(posedge clk_i) disable iff (rst_act)
    1'b1 |=> illegal_seen_o == $past(illegal_o)
  ) else $error("a_r10_seen_is_delayed");

  a_r11_index_hits_hot_bit: assert property (
    @(posedge clk_i) disable iff (rst_act)
    !illegal_o |-> state_o[idx_o]
  ) else $error("a_r11_index_hits_hot_bit");

endmodule

bind onehot_guard_fsm onehot_guard_fsm_chk #(
  .STATE_W(STATE_W),
  .IDX_W  (IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_act       (rst_act),
  .advance_i     (advance_i),
  .inj_mask_i    (inj_mask_i),
  .state_o       (state_o),
  .illegal_o     (illegal_o),
  .illegal_seen_o(illegal_seen_o),
  .idx_o         (idx_o)
);

// File: tb/onehot_guard_fsm_bench.sv
module onehot_guard_fsm_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv;
  logic [15:0] inj;
  logic [15:0] st;
  logic        ill;
  logic        seen;
  logic [3:0]  idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] exp_st;
  logic        exp_seen;

  always #5 clk = ~clk;

  onehot_guard_fsm u_onehot_guard_fsm (
    .clk_i         (clk),
    .rst_n_i       (rst_n),
    .advance_i     (adv),
    .inj_mask_i    (inj),
    .state_o       (st),
    .illegal_o     (ill),
    .illegal_seen_o(seen),
    .idx_o         (idx)
  );

  function automatic int pop16(logic [15:0] v);
    int n = 0;
    for (int b = 0; b < 16; b++) n += int'(v[b]);
    return n;
  endfunction

  function automatic logic [3:0] low16(logic [15:0] v);
    for (int b = 0; b < 16; b++) if (v[b]) return 4'(b);
    return 4'd0;
  endfunction

  function automatic logic [15:0] base_next(logic [15:0] v, logic a);
    if (pop16(v) != 1) return 16'h0001;
    if (a) return {v[14:0], v[15]};
    return v;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Compare all outputs against the tracked expectation
  task automatic check_all(string tag_st);
    check(tag_st, 32'(st), 32'(exp_st));
    check("R4", 32'(ill), 32'(pop16(exp_st) != 1));
    check("R10", 32'(seen), 32'(exp_seen));
    check("R11", 32'(idx), 32'(low16(exp_st)));
  endtask

  // Called at a falling edge: drive, take one rising edge, land on next falling edge
  task automatic step(logic a, logic [15:0] m, string tag_st);
    adv = a;
    inj = m;
    exp_seen = (pop16(exp_st) != 1);
    exp_st   = base_next(exp_st, a) ^ m;
    @(posedge clk);
    @(negedge clk);
    check_all(tag_st);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    adv   = 1'b1;
    inj   = 16'h0000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", 32'(st), 32'h0001);
    check("R10", 32'(seen), 32'd0);
    check("R4", 32'(ill), 32'd0);

    // R3: synchronous release with advance held high
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3", 32'(st), 32'h0001);
    @(posedge clk); @(negedge clk);
    check("R3", 32'(st), 32'h0001);
    @(posedge clk); @(negedge clk);
    check("R3", 32'(st), 32'h0002);
    exp_st   = 16'h0002;
    exp_seen = 1'b0;

    // R7: full rotation including wrap from bit 15 to bit 0
    for (int i = 0; i < 17; i++) step(1'b1, 16'h0000, "R7");

    // R8: hold with advance low
    for (int i = 0; i < 3; i++) step(1'b0, 16'h0000, "R8");

    // R5: the many-bit vector must be caught, then R6 recovers with advance high
    step(1'b1, base_next(exp_st, 1'b1) ^ 16'hFEC1, "R9");
    check("R5", 32'(ill), 32'd1);
    step(1'b1, 16'h0000, "R6");
    check("R6", 32'(st), 32'h0001);
    check("R10", 32'(seen), 32'd1);

    // R6 with a zero vector and advance high
    step(1'b0, base_next(exp_st, 1'b0), "R9");
    check("R4", 32'(ill), 32'd1);
    step(1'b1, 16'h0000, "R6");
    check("R6", 32'(st), 32'h0001);

    // R4, R9, R10, R11: steer the register through every vector
    for (int v = 0; v < 65536; v++) begin
      step(1'b0, base_next(exp_st, 1'b0) ^ 16'(v), "R9");
    end
    // last vector 16'hFFFF is illegal: recovery follows
    step(1'b0, 16'h0000, "R6");

    // R2: asynchronous assertion between edges after an illegal cycle
    step(1'b0, base_next(exp_st, 1'b0) ^ 16'h0030, "R9");
    step(1'b0, 16'h0000, "R6");
    check("R10", 32'(seen), 32'd1);
    #2;
    rst_n = 1'b0;
    #1;
    check("R2", 32'(st), 32'h0001);
    check("R2", 32'(seen), 32'd0);
    @(negedge clk);
    check("R1", 32'(st), 32'h0001);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule